// File: doc/BRIEF.md
# Bit-Serial Coefficient Multiplier

This block multiplies a two's-complement data word that arrives one bit per clock, least significant bit first, by a two's-complement coefficient presented in parallel. The product leaves the block one bit per clock, also least significant bit first. Internally there is one full-adder cell per coefficient bit. Each cell holds its own carry in a flip-flop. The cells are linked in a chain that runs from the coefficient's most significant bit down to its least significant bit. Each link provides one clock of shift, which weights the partial sum coming from the cell above by two.

A strobe on `start_i` marks bit 0 of a data word. On that cycle the block does three things: it captures the coefficient, it clears every carry in step with the word front as that front reaches each cell, and it restarts the bit counter that repeats the data sign bit once the word's DATA_W bits have arrived. A compile-time model parameter sets how many flip-flops sit on each cell's sum output. Model 0 has none, model 1 has one, and model 2 has two. With two or more, the data stream is skewed from cell to cell so that the chain arithmetic stays aligned.

The coefficient is read as a fixed-point value with FRAC_W fractional bits. `frame_o` pulses on the cycle that carries the product bit aligned with the data word's least significant bit. The FRAC_W fractional product bits leave the block on the cycles just before that pulse.

Top module: `sp_serial_mul`

## Requirements
- R1: Let P = X*C, where X is the DATA_W-bit data word and C is the COEF_W-bit coefficient, both two's complement. Starting PIPE cycles after the `start_i` cycle, `prod_o` carries bits 0 through DATA_W+COEF_W-1 of P, one per cycle, least significant first.
- R2: `frame_o` pulses for one cycle exactly FRAC_W+PIPE cycles after each `start_i` pulse. PIPE is 0 for model 0 and 1 for model 1. For model 2 it is COEF_W+1, because each stage adds one cycle of data skew.
- R3: Data bit i of a word is taken from `data_i` i cycles after the `start_i` cycle, for i from 0 to DATA_W-1. After that, `data_i` is ignored and bit DATA_W-1 (the sign) is repeated until the next `start_i`.
- R4: `coef_i` is sampled only on the `start_i` cycle. Changes to it during the rest of the word do not affect that word's product.
- R5: Words may follow one another every DATA_W+COEF_W cycles with no gap. Each product is then exact, with no carry or partial sum left over from the previous word.
- R6: While reset is held, and after reset until the first `start_i`, `prod_o` and `frame_o` stay 0, whatever `data_i` and `coef_i` do.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Marks bit 0 of a data word; captures the coefficient |
| data_i | input | 1 | Serial data, least significant bit first |
| coef_i | input | COEF_W | Parallel two's-complement coefficient |
| prod_o | output | 1 | Serial product, least significant bit first |
| frame_o | output | 1 | Marks the product bit aligned with the data least significant bit |

## Verification
On every cycle, the assertions check four things:
- `frame_o` never fires unless a start is still outstanding.
- The repeated sign bit stays steady once a word's data bits are used up.
- The captured coefficient changes only on a start.
- The outputs stay quiet between reset and the first word.

Only the bench scenarios can show that the serial products are numerically correct. They do this for all three latency models side by side. The scenarios cover extreme negative operands, back-to-back words, and junk on `data_i` and `coef_i` during the word. They also confirm that each model's framing pulse lands on its own expected cycle.

// File: rtl/sp_mul_pkg.sv
package sp_mul_pkg;
  // shift register inserted between cells when the cell itself has no output flop
  function automatic int link_regs(input int model);
    return (model == 0) ? 1 : 0;
  endfunction

  // extra data delay per stage needed to keep the chain aligned
  function automatic int skew_step(input int model);
    return model + link_regs(model) - 1;
  endfunction

  // cycles from data bit 0 to product bit 0
  function automatic int pipe_lat(input int model, input int cw);
    return (cw - 1) * skew_step(model) + model;
  endfunction
endpackage

// File: rtl/sp_delay.sv
module sp_delay #(
  parameter int W = 1,
  parameter int D = 1
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] stage_q [D];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < D; i++) stage_q[i] <= '0;
    end else begin
      stage_q[0] <= d_i;
      for (int i = 1; i < D; i++) stage_q[i] <= stage_q[i-1];
    end
  end

  assign q_o = stage_q[D-1];
endmodule

// File: rtl/sp_in_ext.sv
module sp_in_ext #(
  parameter int DW = 8,
  parameter int CW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  input  logic          bit_i,
  input  logic [CW-1:0] coef_i,
  output logic          bit_o,
  output logic [CW-1:0] coef_cur_o
);
  localparam int CNT_W = $clog2(DW + 1);
  localparam logic [CNT_W-1:0] FULL  = CNT_W'(DW);
  localparam logic [CNT_W-1:0] LASTB = CNT_W'(DW - 1);

  logic [CNT_W-1:0] cnt_q, idx;
  logic             sign_q;
  logic [CW-1:0]    coef_q;

  assign idx = start_i ? '0 : cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= FULL;
      sign_q <= 1'b0;
      coef_q <= '0;
    end else begin
      cnt_q  <= (idx == FULL) ? FULL : idx + 1'b1;
      if (idx == LASTB) sign_q <= bit_i;
      if (start_i) coef_q <= coef_i;
    end
  end

  assign bit_o      = (idx < FULL) ? bit_i : sign_q;
  assign coef_cur_o = start_i ? coef_i : coef_q;

  assert_sign_repeat_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!start_i && cnt_q == FULL) |=> (start_i || bit_o == $past(bit_o)));

  assert_coef_hold_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !start_i |=> $stable(coef_q));
endmodule

// File: rtl/sp_cell.sv
module sp_cell #(
  parameter int MODEL  = 1,
  parameter bit IS_MSB = 1'b0
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  input  logic x_i,
  input  logic coef_bit_i,
  input  logic sum_i,
  output logic sum_o
);
  logic c_q, carry_q, c_eff, pp, a_in, cin, fa_s, fa_c;

  assign c_eff = start_i ? coef_bit_i : c_q;
  assign a_in  = start_i ? 1'b0 : sum_i;

  // sign bit of the coefficient has negative weight: add ~x plus one
  always_comb begin
    if (IS_MSB) begin
      pp  = c_eff & ~x_i;
      cin = start_i ? c_eff : carry_q;
    end else begin
      pp  = c_eff & x_i;
      cin = start_i ? 1'b0 : carry_q;
    end
  end

  assign fa_s = pp ^ a_in ^ cin;
  assign fa_c = (pp & a_in) | (pp & cin) | (a_in & cin);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      c_q     <= 1'b0;
      carry_q <= 1'b0;
    end else begin
      c_q     <= c_eff;
      carry_q <= fa_c;
    end
  end

  if (MODEL == 0) begin : g_comb
    assign sum_o = fa_s;
  end else begin : g_pipe
    sp_delay #(.W(1), .D(MODEL)) u_out (
      .clk_i(clk_i), .rst_ni(rst_ni), .d_i(fa_s), .q_o(sum_o)
    );
  end
endmodule

// File: rtl/sp_serial_mul.sv
module sp_serial_mul
  import sp_mul_pkg::*;
#(
  parameter int DATA_W    = 8,
  parameter int COEF_W    = 8,
  parameter int FRAC_W    = 6,
  parameter int LAT_MODEL = 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic              data_i,
  input  logic [COEF_W-1:0] coef_i,
  output logic              prod_o,
  output logic              frame_o
);
  localparam int LINK  = link_regs(LAT_MODEL);
  localparam int SKEW  = skew_step(LAT_MODEL);
  localparam int PIPE  = pipe_lat(LAT_MODEL, COEF_W);
  localparam int TOTAL = FRAC_W + PIPE;

  logic              x_ext;
  logic [COEF_W-1:0] coef_cur;
  logic              cell_sum [COEF_W];
  logic              chain_in [COEF_W];

  sp_in_ext #(.DW(DATA_W), .CW(COEF_W)) u_in (
    .clk_i(clk_i), .rst_ni(rst_ni), .start_i(start_i), .bit_i(data_i),
    .coef_i(coef_i), .bit_o(x_ext), .coef_cur_o(coef_cur)
  );

  for (genvar k = 0; k < COEF_W; k++) begin : g_cell
    localparam int TAP = (COEF_W - 1 - k) * SKEW;
    logic [1:0] tap;

    if (TAP == 0) begin : g_notap
      assign tap = {start_i, x_ext};
    end else begin : g_tap
      sp_delay #(.W(2), .D(TAP)) u_skew (
        .clk_i(clk_i), .rst_ni(rst_ni), .d_i({start_i, x_ext}), .q_o(tap)
      );
    end

    if (k == COEF_W - 1) begin : g_top
      assign chain_in[k] = 1'b0;
    end else if (LINK == 0) begin : g_direct
      assign chain_in[k] = cell_sum[k+1];
    end else begin : g_link
      sp_delay #(.W(1), .D(LINK)) u_link (
        .clk_i(clk_i), .rst_ni(rst_ni), .d_i(cell_sum[k+1]), .q_o(chain_in[k])
      );
    end

    sp_cell #(.MODEL(LAT_MODEL), .IS_MSB(k == COEF_W - 1)) u_cell (
      .clk_i(clk_i), .rst_ni(rst_ni), .start_i(tap[1]), .x_i(tap[0]),
      .coef_bit_i(coef_cur[k]), .sum_i(chain_in[k]), .sum_o(cell_sum[k])
    );
  end

  assign prod_o = cell_sum[0];

  if (TOTAL == 0) begin : g_frame0
    assign frame_o = start_i;
  end else begin : g_frame
    sp_delay #(.W(1), .D(TOTAL)) u_frame (
      .clk_i(clk_i), .rst_ni(rst_ni), .d_i(start_i), .q_o(frame_o)
    );
  end

  // checker state
  logic [3:0] pend_q;
  logic       seen_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_q <= '0;
      seen_q <= 1'b0;
    end else begin
      pend_q <= pend_q + {3'b0, start_i} - {3'b0, frame_o};
      if (start_i) seen_q <= 1'b1;
    end
  end

  assert_frame_after_start_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frame_o |-> (pend_q != 4'd0 || start_i));

  assert_quiet_after_reset_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!seen_q && !start_i) |-> (!prod_o && !frame_o));
endmodule

// File: tb/sp_serial_mul_tb.sv
module sp_serial_mul_tb;
  localparam int DW   = 8;
  localparam int CW   = 8;
  localparam int FR   = 6;
  localparam int PW   = DW + CW;
  localparam int LOG  = 2048;
  localparam int NV   = 10;
  // expected latency to frame per model 0,1,2
  localparam int LAT0 = FR + 0;
  localparam int LAT1 = FR + 1;
  localparam int LAT2 = FR + (CW - 1) + 2;

  typedef struct packed {
    logic [7:0] x;
    logic [7:0] c;
    logic [7:0] gap;
  } vec_t;

  localparam vec_t VEC [NV] = '{
    '{8'h05, 8'h03, 8'd4},  '{8'hFF, 8'hFF, 8'd0},
    '{8'h80, 8'h80, 8'd0},  '{8'h7F, 8'h80, 8'd0},
    '{8'h80, 8'h7F, 8'd3},  '{8'h00, 8'hB3, 8'd0},
    '{8'h01, 8'hFF, 8'd0},  '{8'hFD, 8'h40, 8'd20},
    '{8'h55, 8'hAA, 8'd0},  '{8'hD6, 8'h01, 8'd5}
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic data = 1'b0;
  logic [CW-1:0] coef = '0;
  logic prod [3];
  logic frame [3];

  logic prod_log [3][LOG];
  logic frame_log [3][LOG];
  int   idx = 0;
  int   n_chk = 0;
  int   n_bad = 0;
  int   s_idx [NV];

  always #2 clk = ~clk;

  sp_serial_mul #(.DATA_W(DW), .COEF_W(CW), .FRAC_W(FR), .LAT_MODEL(0)) u_dut_m0 (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .data_i(data), .coef_i(coef),
    .prod_o(prod[0]), .frame_o(frame[0]));
  sp_serial_mul #(.DATA_W(DW), .COEF_W(CW), .FRAC_W(FR), .LAT_MODEL(1)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .data_i(data), .coef_i(coef),
    .prod_o(prod[1]), .frame_o(frame[1]));
  sp_serial_mul #(.DATA_W(DW), .COEF_W(CW), .FRAC_W(FR), .LAT_MODEL(2)) u_dut_m2 (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .data_i(data), .coef_i(coef),
    .prod_o(prod[2]), .frame_o(frame[2]));

  function automatic int lat_of(input int d);
    return (d == 0) ? LAT0 : (d == 1) ? LAT1 : LAT2;
  endfunction

  task automatic summary();
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  endtask

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // drive at negedge, sample just before the consuming edge
  task automatic tick(input logic st, input logic b, input logic [CW-1:0] c);
    @(negedge clk);
    start = st; data = b; coef = c;
    #1;
    if (idx < LOG) begin
      for (int d = 0; d < 3; d++) begin
        prod_log[d][idx]  = prod[d];
        frame_log[d][idx] = frame[d];
      end
    end
    idx++;
  endtask

  initial begin
    #(4 * 100000);
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=0 expected=1");
    summary();
  end

  initial begin
    // R6: reset held with busy inputs, then idle after release
    for (int i = 0; i < 3; i++) begin
      tick(1'b0, 1'b1, '1);
      for (int d = 0; d < 3; d++)
        check(prod[d] == 1'b0 && frame[d] == 1'b0, "R6 reset", {prod[d], frame[d]}, 0);
    end
    @(negedge clk) rst_n = 1'b1;
    for (int i = 0; i < 6; i++) begin
      tick(1'b0, i[0], CW'(i * 37));
      for (int d = 0; d < 3; d++)
        check(prod[d] == 1'b0 && frame[d] == 1'b0, "R6 idle", {prod[d], frame[d]}, 0);
    end

    // vector table: junk on data_i past DW bits (R3) and coef_i after start (R4)
    for (int w = 0; w < NV; w++) begin
      s_idx[w] = idx;
      tick(1'b1, VEC[w].x[0], VEC[w].c);
      for (int i = 1; i < PW; i++)
        tick(1'b0, (i < DW) ? VEC[w].x[i] : ~VEC[w].x[DW-1], ~VEC[w].c);
      for (int g = 0; g < int'(VEC[w].gap); g++)
        tick(1'b0, ~VEC[w].x[DW-1], ~VEC[w].c);
    end
    for (int i = 0; i < 40; i++) tick(1'b0, 1'b1, '1);

    for (int w = 0; w < NV; w++) begin
      logic signed [PW-1:0] p;
      string tag;
      p   = $signed(VEC[w].x) * $signed(VEC[w].c);
      tag = (w > 0 && VEC[w-1].gap == 0) ? "R5/R1/R3/R4" : "R1/R3/R4";
      for (int d = 0; d < 3; d++) begin
        int t;
        logic [PW-1:0] got;
        t = s_idx[w] + lat_of(d);
        // R2: single pulse at the model's latency
        check(frame_log[d][t] && !frame_log[d][t-1] && !frame_log[d][t+1],
              $sformatf("R2 model%0d word%0d", d, w),
              {frame_log[d][t-1], frame_log[d][t], frame_log[d][t+1]}, 3'b010);
        for (int i = 0; i < PW; i++) got[i] = prod_log[d][t - FR + i];
        check(got == p, $sformatf("%s model%0d word%0d", tag, d, w), got, p);
      end
    end
    summary();
  end
endmodule